// File: doc/BRIEF.md
# T1 Receive Signal-Loss and All-Ones Alarm Monitor

This block watches the recovered receive bit stream of a T1 line, one bit for each pulse of a bit-valid strobe. It raises a loss-of-signal flag when the line goes quiet for a long run of zeros. The flag drops again only after the line carries enough ones over a recent stretch of traffic. A second flag reports an alarm indication signal, which is a stream of almost all ones. That flag is only evaluated while an external framer says it has lost frame alignment.

The recovery test counts the ones in the most recent 386 received bits, which is two 193-bit frames. This count is taken over a sliding history. The history is emptied whenever the loss flag is low, so after an alarm it counts only the bits received since the alarm. The all-ones test uses back-to-back fixed windows of 386 bits, which is about 250 microseconds at the line rate. Window timing restarts each time the framer loses alignment. Both flags are registered, and an asynchronous active-low reset clears them. The block releases that reset synchronously through a two-stage synchroniser.

Top module: `t1_los_ais_mon`

## Requirements
- R1: While reset is held low, both `los` and `ais` read 0.
- R2: `los` goes to 1 on the clock edge that takes in the 128th consecutive received zero, and not earlier.
- R3: A received one restarts the zero-run count, so 127 zeros, a one and 127 more zeros leave `los` at 0.
- R4: While `los` is 1, it returns to 0 on the edge that takes in the bit that brings the number of ones among the last 386 received bits to 48. At 47 ones it stays 1.
- R5: Ones received more than 386 bits back, or received before `los` last rose, do not count toward the recovery total of R4.
- R6: Clock cycles with `bit_en` low have no effect: `rx_bit` is ignored and `los` does not change.
- R7: While `framer_sync` is 0, `ais` goes to 1 at the end of a 386-bit window that holds two or fewer zeros. The window is counted from the cycle after `framer_sync` fell, or from the previous window end. `ais` changes only at a window end.
- R8: At the end of a window that holds three or more zeros, `ais` goes to 0.
- R9: `framer_sync` = 1 forces `ais` to 0 on the next edge and restarts window timing.
- R10: A reset in mid-operation clears both flags and the zero-run count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | High for one cycle per received line bit |
| rx_bit | input | 1 | Received line bit, valid when `bit_en` is high |
| framer_sync | input | 1 | 1 while the external framer holds frame alignment |
| los | output | 1 | Loss-of-signal flag |
| ais | output | 1 | Alarm indication signal flag |

## Verification
On every cycle, the assertions check these properties: the zero-run count stays saturated and a received one empties it; the running ones total always equals the population of the history register; `los` rises only when a zero run completes and holds when no strobe is present; and `ais` moves only at a window end or when the framer regains alignment. The exact thresholds can only be shown by the directed scenarios: 127 against 128 zeros, 47 against 48 ones, and two against three zeros per window. The same holds for ones sliding out of the history and for the zero-run count being cleared by a mid-run reset.

// File: rtl/t1_mon_pkg.sv
package t1_mon_pkg;
  localparam int unsigned FRAME_BITS    = 193;
  localparam int unsigned WIN_BITS      = 2 * FRAME_BITS;
  localparam int unsigned ZERO_RUN      = 128;
  localparam int unsigned ONES_RECOVER  = 48;
  localparam int unsigned AIS_MAX_ZEROS = 2;
endpackage

// File: rtl/t1_rst_sync.sv
module t1_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      rst_sn  <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      rst_sn  <= stage_q;
    end
  end
endmodule

// File: rtl/t1_zero_run.sv
module t1_zero_run #(
  parameter int unsigned ZERO_RUN = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic rx_bit,
  output logic run_hit
);
  localparam int unsigned CW = $clog2(ZERO_RUN + 1);
  localparam logic [CW-1:0] RUN_MAX  = CW'(ZERO_RUN);
  localparam logic [CW-1:0] RUN_LAST = CW'(ZERO_RUN - 1);

  logic [CW-1:0] zc_q, zc_d;

  always_comb begin
    zc_d = zc_q;
    if (bit_en) begin
      if (rx_bit)
        zc_d = '0;
      else if (zc_q != RUN_MAX)
        zc_d = zc_q + 1'b1;
    end
  end

  assign run_hit = bit_en && !rx_bit && (zc_q >= RUN_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) zc_q <= '0;
    else        zc_q <= zc_d;
  end

  // R2: the run count never passes its saturation point
  a_r2_run_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    zc_q <= RUN_MAX);

  // R3: a received one empties the run count
  a_r3_one_restarts_run: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && rx_bit) |=> (zc_q == '0));
endmodule

// File: rtl/t1_ones_window.sv
module t1_ones_window #(
  parameter int unsigned WIN_BITS     = 386,
  parameter int unsigned ONES_RECOVER = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic bit_en,
  input  logic rx_bit,
  output logic dens_ok
);
  localparam int unsigned CW = $clog2(WIN_BITS + 1);
  localparam logic [CW-1:0] RECOVER_AT = CW'(ONES_RECOVER);

  logic [WIN_BITS-1:0] hist_q, hist_d;
  logic [CW-1:0]       cnt_q, cnt_d;
  logic                oldest;

  assign oldest = hist_q[WIN_BITS-1];

  always_comb begin
    hist_d = hist_q;
    cnt_d  = cnt_q;
    if (clr) begin
      hist_d = '0;
      cnt_d  = '0;
    end else if (bit_en) begin
      hist_d = {hist_q[WIN_BITS-2:0], rx_bit};
      cnt_d  = cnt_q + CW'(rx_bit) - CW'(oldest);
    end
  end

  assign dens_ok = !clr && bit_en && (cnt_d >= RECOVER_AT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      cnt_q  <= '0;
    end else begin
      hist_q <= hist_d;
      cnt_q  <= cnt_d;
    end
  end

  // R5: running total agrees with the ones held in the history
  a_r5_total_tracks_history: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q == CW'($countones(hist_q)));

  // R5: a cleared window holds no ones on the following cycle
  a_r5_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/t1_ais_mon.sv
module t1_ais_mon #(
  parameter int unsigned WIN_BITS  = 386,
  parameter int unsigned MAX_ZEROS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic rx_bit,
  input  logic framer_sync,
  output logic ais
);
  localparam int unsigned PW = $clog2(WIN_BITS);
  localparam int unsigned ZW = $clog2(MAX_ZEROS + 2);
  localparam logic [PW-1:0] POS_LAST = PW'(WIN_BITS - 1);
  localparam logic [ZW-1:0] Z_SAT    = ZW'(MAX_ZEROS + 1);
  localparam logic [ZW-1:0] Z_OK     = ZW'(MAX_ZEROS);

  logic [PW-1:0] pos_q, pos_d;
  logic [ZW-1:0] zw_q, zw_d, zsum;
  logic          ais_q, ais_d;
  logic          at_end;

  assign at_end = bit_en && !framer_sync && (pos_q == POS_LAST);

  always_comb begin
    zsum = zw_q;
    if (!rx_bit && (zw_q != Z_SAT))
      zsum = zw_q + 1'b1;
  end

  always_comb begin
    pos_d = pos_q;
    zw_d  = zw_q;
    ais_d = ais_q;
    if (framer_sync) begin
      pos_d = '0;
      zw_d  = '0;
      ais_d = 1'b0;
    end else if (bit_en) begin
      if (pos_q == POS_LAST) begin
        pos_d = '0;
        zw_d  = '0;
        ais_d = (zsum <= Z_OK);
      end else begin
        pos_d = pos_q + 1'b1;
        zw_d  = zsum;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      zw_q  <= '0;
      ais_q <= 1'b0;
    end else begin
      pos_q <= pos_d;
      zw_q  <= zw_d;
      ais_q <= ais_d;
    end
  end

  assign ais = ais_q;

  // R9: regained alignment clears the flag on the next edge
  a_r9_sync_clears: assert property (@(posedge clk) disable iff (!rst_n)
    framer_sync |=> !ais_q);

  // R7: without a window end the flag holds
  a_r7_moves_only_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (!framer_sync && !at_end) |=> $stable(ais_q));

  // R7: position stays inside the window
  a_r7_pos_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= POS_LAST);
endmodule

// File: rtl/t1_los_ais_mon.sv
module t1_los_ais_mon
  import t1_mon_pkg::*;
#(
  parameter int unsigned WIN      = WIN_BITS,
  parameter int unsigned RUN      = ZERO_RUN,
  parameter int unsigned RECOVER  = ONES_RECOVER,
  parameter int unsigned AIS_ZMAX = AIS_MAX_ZEROS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic rx_bit,
  input  logic framer_sync,
  output logic los,
  output logic ais
);
  logic rst_sn;
  logic run_hit, dens_ok;
  logic los_q, los_d;

  t1_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  t1_zero_run #(.ZERO_RUN(RUN)) u_run (
    .clk     (clk),
    .rst_n   (rst_sn),
    .bit_en  (bit_en),
    .rx_bit  (rx_bit),
    .run_hit (run_hit)
  );

  t1_ones_window #(.WIN_BITS(WIN), .ONES_RECOVER(RECOVER)) u_dens (
    .clk     (clk),
    .rst_n   (rst_sn),
    .clr     (!los_q),
    .bit_en  (bit_en),
    .rx_bit  (rx_bit),
    .dens_ok (dens_ok)
  );

  t1_ais_mon #(.WIN_BITS(WIN), .MAX_ZEROS(AIS_ZMAX)) u_ais (
    .clk         (clk),
    .rst_n       (rst_sn),
    .bit_en      (bit_en),
    .rx_bit      (rx_bit),
    .framer_sync (framer_sync),
    .ais         (ais)
  );

  always_comb begin
    if (los_q) los_d = !dens_ok;
    else       los_d = run_hit;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) los_q <= 1'b0;
    else         los_q <= los_d;
  end

  assign los = los_q;

  // R2: the flag rises only when a zero run completes
  a_r2_rise_needs_run: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(los_q) |-> $past(run_hit));

  // R4: the flag falls only when the density test passes
  a_r4_fall_needs_density: assert property (@(posedge clk) disable iff (!rst_sn)
    $fell(los_q) |-> $past(dens_ok));

  // R6: no strobe, no change
  a_r6_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_sn)
    !bit_en |=> $stable(los_q));
endmodule

// File: tb/tb_t1_los_ais_mon.sv
module tb_t1_los_ais_mon;
  logic clk = 1'b0;
  logic rst_n, bit_en, rx_bit, framer_sync;
  logic los, ais;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  t1_los_ais_mon dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
    .framer_sync(framer_sync), .los(los), .ais(ais)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_en = 1'b1;
    rx_bit = b;
    @(negedge clk);
    bit_en = 1'b0;
  endtask

  task automatic send_run(input logic b, input int n);
    for (int i = 0; i < n; i++) send_bit(b);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; bit_en = 1'b0; rx_bit = 1'b0; framer_sync = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 los in reset", los, 1'b0);
    chk("R1 ais in reset", ais, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_strobe_ignored;
    rx_bit = 1'b0;
    repeat (300) @(negedge clk);
    chk("R6 idle zeros ignored", los, 1'b0);
    send_run(1'b0, 127);
    chk("R6 run not advanced by idle cycles", los, 1'b0);
    send_bit(1'b1);
  endtask

  task automatic t_zero_run;
    send_run(1'b0, 127);
    send_bit(1'b1);
    send_run(1'b0, 127);
    chk("R3 one restarts run", los, 1'b0);
    send_bit(1'b0);
    chk("R2 128th zero sets los", los, 1'b1);
  endtask

  task automatic t_recover;
    send_run(1'b1, 47);
    chk("R4 47 ones keep los", los, 1'b1);
    send_bit(1'b1);
    chk("R4 48th one clears los", los, 1'b0);
  endtask

  task automatic t_slide;
    send_run(1'b0, 128);
    chk("R2 los set again", los, 1'b1);
    send_run(1'b1, 40);
    send_run(1'b0, 386);
    chk("R5 zeros keep los", los, 1'b1);
    send_run(1'b1, 8);
    chk("R5 old ones slid out", los, 1'b1);
    send_run(1'b1, 39);
    chk("R5 47 recent ones keep los", los, 1'b1);
    send_bit(1'b1);
    chk("R4 48 recent ones clear los", los, 1'b0);
  endtask

  task automatic t_ais;
    @(negedge clk);
    framer_sync = 1'b0;
    for (int i = 0; i < 385; i++) send_bit((i == 50 || i == 200) ? 1'b0 : 1'b1);
    chk("R7 no ais before window end", ais, 1'b0);
    send_bit(1'b1);
    chk("R7 two zeros in window sets ais", ais, 1'b1);
    for (int i = 0; i < 385; i++) send_bit((i == 10 || i == 20 || i == 30) ? 1'b0 : 1'b1);
    chk("R7 ais holds mid window", ais, 1'b1);
    send_bit(1'b1);
    chk("R8 three zeros clear ais", ais, 1'b0);
    send_run(1'b1, 386);
    chk("R7 all ones sets ais", ais, 1'b1);
    @(negedge clk);
    framer_sync = 1'b1;
    @(negedge clk);
    chk("R9 sync clears ais", ais, 1'b0);
    send_run(1'b1, 800);
    chk("R9 no ais while in sync", ais, 1'b0);
  endtask

  task automatic t_mid_reset;
    send_run(1'b0, 128);
    chk("R10 los set before reset", los, 1'b1);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10 reset clears los", los, 1'b0);
    chk("R10 reset clears ais", ais, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    send_bit(1'b0);
    chk("R10 run count cleared", los, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_strobe_ignored();
    t_zero_run();
    t_recover();
    t_slide();
    t_ais();
    t_mid_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule